// File: doc/BRIEF.md
# Externally Strobed Bidirectional FIFO Port

This block is a slave-side port between an external device and a pair of on-chip FIFOs. The external device supplies a strobe clock and a direction level. At every rising strobe edge the port either presents the oldest transmit word on a shared data bus or takes a word from that bus into the receive FIFO. Internal logic runs on a system clock. On that side it pushes words for transmission, pops received words, and watches a sticky overflow interrupt.

An output to the external device, the read request, tells it that transmit data is waiting. The device is expected to issue reads only while this output is high. A read made while nothing is waiting is an error and consumes nothing. Writes are never throttled. A write that finds the receive FIFO full is discarded, and the overflow interrupt latches. Two configuration bits enable the port: it operates only with the slave-select bit at 1 and the clock-drive bit at 0.

Top module: `xstrobe_fifo_port`

## Requirements
- R1: While reset is held, xrreq, rx_valid, ovf_irq and xoe are 0 and tx_ready is 1.
- R2: A rising strobe edge with xdir=1 and transmit data present pops one word, drives it on xdata and raises xoe until the next falling strobe edge. Words leave in push order.
- R3: A rising strobe edge with xdir=0 captures xdata into the receive FIFO with xoe low. Captured words reach rx_data in order, handshaked by rx_valid/rx_ready.
- R4: xrreq rises at most one system clock after a transmit push. It stays high while unread words remain, and it falls no later than one system-clock period after the rising strobe edge of the read that takes the last word.
- R5: A read strobe with the transmit FIFO empty leaves xoe low and removes nothing. The next word pushed is the next word read.
- R6: A write strobe while the receive FIFO holds DEPTH words discards the word and sets ovf_irq. A discarded word never appears on rx_data.
- R7: ovf_irq stays set until a one-cycle ovf_clr pulse. A new overflow in the same cycle as the clear keeps it set.
- R8: Unless mode_sel=1 and clk_out_en=0, strobes neither pop nor capture, and xrreq and xoe stay 0.
- R9: tx_ready is 0 once the transmit FIFO holds DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the internal side |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Slave port select (1 = enabled) |
| clk_out_en | input | 1 | Clock-drive mode bit (must be 0 for this port) |
| tx_valid | input | 1 | Push request into transmit FIFO |
| tx_data | input | DW | Word to transmit |
| tx_ready | output | 1 | Transmit FIFO can accept a word |
| rx_valid | output | 1 | Received word available |
| rx_data | output | DW | Oldest received word |
| rx_ready | input | 1 | Pop the received word |
| ovf_irq | output | 1 | Sticky receive overflow interrupt |
| ovf_clr | input | 1 | Write-one-to-clear pulse for ovf_irq |
| xstb | input | 1 | External strobe clock |
| xdir | input | 1 | External direction (1 = read, 0 = write) |
| xdata | inout | DW | Shared external data bus |
| xoe | output | 1 | Port is driving xdata |
| xrreq | output | 1 | Read request to the external device |

## Verification
A corrupted transmit read pointer shows up on the very next read strobe: the wrong word appears on xdata, or a word is missing. A stale pointer copy on the system side makes xrreq stay high past the one-period window after the emptying read, and that error is visible within 21 ns of the strobe edge. A wrong full decision on the receive side lets a discarded word through to rx_data, or drops a legal word. Either shows as a scoreboard mismatch once the receive queue drains, a few system clocks later. A broken overflow flag shows as a missing or self-clearing interrupt within a handful of cycles.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_READ,
    CYC_EMPTY_RD,
    CYC_WRITE,
    CYC_DROP
  } xsp_cyc_e;
endpackage

// File: rtl/xsp_sync.sv
module xsp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 1) begin : g_one
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d;
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      assign q = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/xsp_gray_ptr.sv
module xsp_gray_ptr #(
  parameter int AW = 3,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray
);
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + {{(PW-1){1'b0}}, inc};
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (inc) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end

  assign bin  = bin_q;
  assign gray = gray_q;
endmodule

// File: rtl/xsp_dpram.sv
module xsp_dpram #(
  parameter int AW = 3,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk)
    if (we) mem[waddr] <= wdata;

  assign rdata = mem[raddr];
endmodule

// File: rtl/xstrobe_fifo_port.sv
module xstrobe_fifo_port #(
  parameter int DW = 8,
  parameter int AW = 3,
  localparam int PW = AW + 1
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          clk_out_en,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  output logic          ovf_irq,
  input  logic          ovf_clr,
  input  logic          xstb,
  input  logic          xdir,
  inout  wire  [DW-1:0] xdata,
  output logic          xoe,
  output logic          xrreq
);
  import xsp_pkg::*;

  // system-domain reset: asserted asynchronously, released on sys_clk
  logic [1:0] rst_sync_q;
  logic       rst_sys_n;
  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  assign rst_sys_n = rst_sync_q[1];

  logic active;
  assign active = mode_sel & ~clk_out_en;

  // ---------------- transmit path: sys writes, strobe reads ----------------
  logic [PW-1:0] tx_wbin, tx_wgray, tx_rbin, tx_rgray;
  logic [PW-1:0] tx_rgray_s1, tx_rgray_s2;
  logic [DW-1:0] tx_head;
  logic          tx_push, tx_empty_x;
  xsp_cyc_e      cyc;

  assign tx_push = tx_valid & tx_ready;

  xsp_gray_ptr #(.AW(AW)) u_tx_wptr (
    .clk(sys_clk), .rst_n(rst_sys_n), .inc(tx_push), .bin(tx_wbin), .gray(tx_wgray));
  xsp_gray_ptr #(.AW(AW)) u_tx_rptr (
    .clk(xstb), .rst_n(rst_n), .inc(cyc == CYC_READ), .bin(tx_rbin), .gray(tx_rgray));
  xsp_dpram #(.AW(AW), .DW(DW)) u_tx_mem (
    .wclk(sys_clk), .we(tx_push), .waddr(tx_wbin[AW-1:0]), .wdata(tx_data),
    .raddr(tx_rbin[AW-1:0]), .rdata(tx_head));

  // full test uses the safe two-stage copy, request uses the fast one-stage copy
  xsp_sync #(.W(PW), .STAGES(2)) u_tx_rsync2 (
    .clk(sys_clk), .rst_n(rst_sys_n), .d(tx_rgray), .q(tx_rgray_s2));
  xsp_sync #(.W(PW), .STAGES(1)) u_tx_rsync1 (
    .clk(sys_clk), .rst_n(rst_sys_n), .d(tx_rgray), .q(tx_rgray_s1));

  assign tx_ready   = (tx_wgray != {~tx_rgray_s2[PW-1:PW-2], tx_rgray_s2[PW-3:0]});
  assign xrreq      = active & (tx_wgray != tx_rgray_s1);
  assign tx_empty_x = (tx_rgray == tx_wgray);

  // ---------------- receive path: strobe writes, sys reads -----------------
  logic [PW-1:0] rx_wbin, rx_wgray, rx_rbin, rx_rgray, rx_wgray_s2;
  logic          rx_pop, rx_full_x;

  assign rx_pop    = rx_valid & rx_ready;
  assign rx_full_x = (rx_wgray == {~rx_rgray[PW-1:PW-2], rx_rgray[PW-3:0]});

  xsp_gray_ptr #(.AW(AW)) u_rx_wptr (
    .clk(xstb), .rst_n(rst_n), .inc(cyc == CYC_WRITE), .bin(rx_wbin), .gray(rx_wgray));
  xsp_gray_ptr #(.AW(AW)) u_rx_rptr (
    .clk(sys_clk), .rst_n(rst_sys_n), .inc(rx_pop), .bin(rx_rbin), .gray(rx_rgray));
  xsp_dpram #(.AW(AW), .DW(DW)) u_rx_mem (
    .wclk(xstb), .we(cyc == CYC_WRITE), .waddr(rx_wbin[AW-1:0]), .wdata(xdata),
    .raddr(rx_rbin[AW-1:0]), .rdata(rx_data));
  xsp_sync #(.W(PW), .STAGES(2)) u_rx_wsync (
    .clk(sys_clk), .rst_n(rst_sys_n), .d(rx_wgray), .q(rx_wgray_s2));

  assign rx_valid = (rx_rgray != rx_wgray_s2);

  // ---------------- strobe engine ----------------
  logic          oe_rise_q, oe_rise_d, oe_fall_q, ovf_tgl_q, ovf_tgl_d;
  logic [DW-1:0] dout_q, dout_d;

  always_comb begin
    if (!active)           cyc = CYC_IDLE;
    else if (xdir)         cyc = tx_empty_x ? CYC_EMPTY_RD : CYC_READ;
    else                   cyc = rx_full_x  ? CYC_DROP     : CYC_WRITE;
    oe_rise_d = oe_rise_q ^ (cyc == CYC_READ);
    dout_d    = (cyc == CYC_READ) ? tx_head : dout_q;
    ovf_tgl_d = ovf_tgl_q ^ (cyc == CYC_DROP);
  end

  always_ff @(posedge xstb or negedge rst_n)
    if (!rst_n) begin
      oe_rise_q <= 1'b0;
      ovf_tgl_q <= 1'b0;
      dout_q    <= '0;
    end else begin
      oe_rise_q <= oe_rise_d;
      ovf_tgl_q <= ovf_tgl_d;
      dout_q    <= dout_d;
    end

  always_ff @(negedge xstb or negedge rst_n)
    if (!rst_n) oe_fall_q <= 1'b0;
    else        oe_fall_q <= oe_rise_q;

  assign xoe   = active & (oe_rise_q != oe_fall_q);
  assign xdata = xoe ? dout_q : {DW{1'bz}};

  // ---------------- overflow interrupt ----------------
  logic ovf_tgl_s2, ovf_seen_q, ovf_q, ovf_d, ovf_evt;
  xsp_sync #(.W(1), .STAGES(2)) u_ovf_sync (
    .clk(sys_clk), .rst_n(rst_sys_n), .d(ovf_tgl_q), .q(ovf_tgl_s2));

  always_comb begin
    ovf_evt = ovf_tgl_s2 ^ ovf_seen_q;
    ovf_d   = ovf_evt | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge sys_clk or negedge rst_sys_n)
    if (!rst_sys_n) begin
      ovf_seen_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      ovf_seen_q <= ovf_tgl_s2;
      ovf_q      <= ovf_d;
    end

  assign ovf_irq = ovf_q;
endmodule

// File: rtl/xstrobe_fifo_port_chk.sv
module xstrobe_fifo_port_chk #(
  parameter int PW = 4
) (
  input logic          sys_clk,
  input logic          rst_n,
  input logic          xstb,
  input logic          xdir,
  input logic          active,
  input logic          tx_empty_x,
  input logic [PW-1:0] tx_rgray,
  input logic [PW-1:0] rx_wgray,
  input logic          xoe,
  input logic          ovf_irq,
  input logic          ovf_clr
);
  // R2: a read with data present advances the transmit read pointer
  a_r2_read_pops: assert property (@(posedge xstb) disable iff (!rst_n)
    (active && xdir && !tx_empty_x) |=> (tx_rgray != $past(tx_rgray)));

  // R3: the bus is released before every new strobe edge
  a_r3_bus_released: assert property (@(posedge xstb) disable iff (!rst_n) !xoe);

  // R5: a read on an empty FIFO removes nothing
  a_r5_empty_read_no_pop: assert property (@(posedge xstb) disable iff (!rst_n)
    (active && xdir && tx_empty_x) |=> $stable(tx_rgray));

  // R8: strobes while the port is disabled capture nothing
  a_r8_idle_no_capture: assert property (@(posedge xstb) disable iff (!rst_n)
    !active |=> $stable(rx_wgray));

  // R7: the interrupt holds without a clear
  a_r7_ovf_sticky: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (ovf_irq && !ovf_clr) |=> ovf_irq);

  // R7: the interrupt falls only after a clear pulse
  a_r7_ovf_clear_only: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(ovf_irq) |-> $past(ovf_clr));
endmodule

bind xstrobe_fifo_port xstrobe_fifo_port_chk #(.PW(PW)) u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .xstb(xstb), .xdir(xdir), .active(active),
  .tx_empty_x(tx_empty_x), .tx_rgray(tx_rgray), .rx_wgray(rx_wgray),
  .xoe(xoe), .ovf_irq(ovf_irq), .ovf_clr(ovf_clr));

// File: tb/xstrobe_fifo_port_bench.sv
module xstrobe_fifo_port_bench;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic sys_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b1, clk_out_en = 1'b0;
  logic tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_ready = 1'b0;
  logic [DW-1:0] rx_data;
  logic ovf_irq, ovf_clr = 1'b0;
  logic xstb = 1'b0, xdir = 1'b1;
  logic xoe, xrreq;
  logic bdrv = 1'b0;
  logic [DW-1:0] bval = '0;
  wire  [DW-1:0] xbus;

  assign xbus = bdrv ? bval : {DW{1'bz}};

  int n_chk = 0, n_bad = 0;
  logic mon_en = 1'b1;
  logic [DW-1:0] tx_q[$];
  logic [DW-1:0] rx_q[$];

  always #10 sys_clk = ~sys_clk;

  xstrobe_fifo_port #(.DW(DW), .AW(AW)) u_xstrobe_fifo_port (
    .sys_clk(sys_clk), .rst_n(rst_n), .mode_sel(mode_sel), .clk_out_en(clk_out_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .ovf_irq(ovf_irq), .ovf_clr(ovf_clr),
    .xstb(xstb), .xdir(xdir), .xdata(xbus), .xoe(xoe), .xrreq(xrreq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic push(input logic [DW-1:0] w);
    @(negedge sys_clk);
    while (!tx_ready) @(negedge sys_clk);
    tx_valid = 1'b1;
    tx_data  = w;
    tx_q.push_back(w);
    @(negedge sys_clk);
    tx_valid = 1'b0;
  endtask

  // read strobe; has_data selects R2 or R5 expectation, rq is xrreq 21 ns after edge
  task automatic xs_read(input bit has_data, input bit rq);
    logic [DW-1:0] w;
    xdir = 1'b1;
    #13 xstb = 1'b1;
    #4;
    if (has_data) begin
      w = tx_q.pop_front();
      check(xoe === 1'b1, "R2 oe", int'(xoe), 1);
      check(xbus === w, "R2 data", int'(xbus), int'(w));
    end else begin
      check(xoe === 1'b0, "R5/R8 oe on bad read", int'(xoe), 0);
    end
    #8 xstb = 1'b0;
    #9 check(xrreq === rq, "R4 xrreq after read", int'(xrreq), int'(rq));
    #5;
  endtask

  task automatic xs_write(input logic [DW-1:0] v, input bit keep);
    xdir = 1'b0;
    bdrv = 1'b1;
    bval = v;
    #13 xstb = 1'b1;
    #4 check(xoe === 1'b0, "R3 oe during write", int'(xoe), 0);
    #8 xstb = 1'b0;
    #3 bdrv = 1'b0;
    if (keep) rx_q.push_back(v);
    #9;
  endtask

  // scoreboard monitor on the receive pop interface
  initial begin
    forever begin
      @(negedge sys_clk);
      if (mon_en && rx_valid === 1'b1) begin
        if (rx_q.size() == 0) check(1'b0, "R6 unexpected rx word", int'(rx_data), 0);
        else begin
          logic [DW-1:0] e;
          e = rx_q.pop_front();
          check(rx_data === e, "R3 rx order", int'(rx_data), int'(e));
        end
        rx_ready = 1'b1;
      end else begin
        rx_ready = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    wait_clks(4);
    // R1 reset state
    check(xrreq === 1'b0, "R1 xrreq", int'(xrreq), 0);
    check(rx_valid === 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    check(ovf_irq === 1'b0, "R1 ovf_irq", int'(ovf_irq), 0);
    check(xoe === 1'b0, "R1 xoe", int'(xoe), 0);
    check(tx_ready === 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    rst_n = 1'b1;
    wait_clks(4);

    // R2 / R4: ordered reads, request timing
    push(8'hA1); push(8'hB2); push(8'hC3);
    check(xrreq === 1'b1, "R4 xrreq after push", int'(xrreq), 1);
    wait_clks(2);
    xs_read(1'b1, 1'b1);
    xs_read(1'b1, 1'b1);
    xs_read(1'b1, 1'b0);

    // R5: read with nothing waiting removes nothing
    xs_read(1'b0, 1'b0);
    push(8'hD4);
    wait_clks(2);
    xs_read(1'b1, 1'b0);

    // R3: writes arrive in order
    xs_write(8'h11, 1'b1); xs_write(8'h22, 1'b1); xs_write(8'h33, 1'b1);
    wait_clks(10);
    check(rx_q.size() == 0, "R3 all words drained", rx_q.size(), 0);

    // R9: transmit full
    for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i));
    check(tx_ready === 1'b0, "R9 tx_ready when full", int'(tx_ready), 0);
    wait_clks(2);
    for (int i = 0; i < DEPTH; i++) xs_read(1'b1, (i != DEPTH-1));
    wait_clks(4);
    check(tx_ready === 1'b1, "R9 tx_ready after drain", int'(tx_ready), 1);

    // R6 / R7: overflow drops words and latches the interrupt
    mon_en = 1'b0;
    wait_clks(2);
    for (int i = 0; i < DEPTH; i++) xs_write(8'h60 + 8'(i), 1'b1);
    xs_write(8'hEE, 1'b0);
    xs_write(8'hEF, 1'b0);
    wait_clks(6);
    check(ovf_irq === 1'b1, "R6 ovf_irq set", int'(ovf_irq), 1);
    mon_en = 1'b1;
    wait_clks(20);
    check(rx_q.size() == 0, "R6 kept words drained", rx_q.size(), 0);
    check(rx_valid === 1'b0, "R6 no dropped word", int'(rx_valid), 0);
    check(ovf_irq === 1'b1, "R7 ovf sticky", int'(ovf_irq), 1);
    ovf_clr = 1'b1;
    @(negedge sys_clk);
    ovf_clr = 1'b0;
    check(ovf_irq === 1'b0, "R7 ovf cleared", int'(ovf_irq), 0);

    // R8: port disabled
    clk_out_en = 1'b1;
    push(8'h5A);
    wait_clks(4);
    check(xrreq === 1'b0, "R8 xrreq disabled", int'(xrreq), 0);
    xs_write(8'h77, 1'b0);
    xs_read(1'b0, 1'b0);
    wait_clks(6);
    check(rx_valid === 1'b0, "R8 no capture", int'(rx_valid), 0);
    clk_out_en = 1'b0;
    wait_clks(2);
    check(xrreq === 1'b1, "R8 xrreq re-enabled", int'(xrreq), 1);
    xs_read(1'b1, 1'b0);

    wait_clks(5);
    finish_run();
  end
endmodule